// File: doc/BRIEF.md
# PCM Sample Fetch Sequencer

This block walks one wavetable channel through its sample data in memory. Each fetch request reads one 16-bit word over a synchronous read port with one cycle of latency. Every returned word is checked for an in-band end marker before it is handed to the rest of the channel as sample data. The running word address is 22 bits wide. It is built from a 6-bit high segment held in a control word and a separate 16-bit low part. A loop address is formed the same way.

A rising edge on the channel enable starts playback and latches the tone mode and sample format. The playback address is loaded at the same edge. Each later request reads the current address and, unless the word is a marker, advances it by one. On a marker, the tone mode decides what happens next:

- In auto-end mode the channel halts, emits a one-cycle stop pulse and sets a sticky status bit.
- In auto-repeat mode the block jumps to the loop address and fetches that word in place of the marker.
- In software mode, and in the reserved mode, no fetch is ever made, because software supplies the samples.

Top module: `fetch_seq`

## Requirements
- R1: After reset, chan_active, stop_status, stop_pulse, mem_rd_en and sample_valid are all 0.
- R2: While enable is 1 and was 0 on the previous clock, a tone mode of 01 (auto-end) or 10 (auto-repeat) sets chan_active at that edge. The address becomes {ctrl_word[5:0], start_lo}. The mode in ctrl_word[13:12] and the format bit ctrl_word[14] (1 = 16-bit word, 0 = 8-bit) are latched there.
- R3: If the tone mode at the enable rise is 00 (software) or 11 (reserved), chan_active stays 0 and fetch_req never produces a memory read.
- R4: A fetch_req sampled in cycle t on a ready channel drives mem_rd_en with the current address in cycle t+1. The word read appears on sample_data with a one-cycle sample_valid in cycle t+3, provided it is not a marker. The address then advances by one.
- R5: Only one read is outstanding at a time; fetch_req is ignored for the two cycles after it was accepted.
- R6: In 16-bit format only 0xFFFF is an end marker. In 8-bit format a word is a marker when either byte is 0xFF. A marker word never appears with sample_valid.
- R7: A marker in auto-end mode drops chan_active. The same edge also raises stop_pulse for exactly one cycle and sets stop_status, both in cycle t+3.
- R8: A marker in auto-repeat mode issues a read of {ctrl_word[11:6], loop_lo} in cycle t+3 and delivers that word in cycle t+5. Fetching then continues from the loop address plus one, and the channel stays active.
- R9: In auto-repeat mode, if the word at the loop address is itself a marker, the channel stops as in R7.
- R10: stop_status stays set until the next enable rise, which clears it.
- R11: Dropping enable clears chan_active at the next edge and discards any read in flight. No stop pulse is produced and stop_status is left unchanged.
- R12: The 22-bit address wraps from 0x3FFFFF to 0x000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Channel enable; a rising edge starts playback |
| ctrl_word | input | 15 | [5:0] start high, [11:6] loop high, [13:12] tone mode, [14] 16-bit format |
| start_lo | input | 16 | Low 16 bits of the start address |
| loop_lo | input | 16 | Low 16 bits of the loop address |
| fetch_req | input | 1 | Request for the next sample |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 22 | Memory word address |
| mem_rd_data | input | 16 | Read data, valid one cycle after the strobe |
| sample_data | output | 16 | Last delivered sample word |
| sample_valid | output | 1 | One-cycle strobe for sample_data |
| chan_active | output | 1 | Channel is playing |
| stop_pulse | output | 1 | One-cycle pulse when the channel halts on a marker |
| stop_status | output | 1 | Sticky stop flag |

## Verification
The checker holds the following on every cycle:
- a read strobe never lasts two cycles;
- a strobe only occurs on an active channel;
- every sample strobe is preceded by a read two cycles earlier;
- an 0xFFFF word is never delivered;
- the stop pulse is single-cycle and arrives with the status set and the channel idle;
- a channel never starts with the status still set.

Only the bench scenarios can show the rest, because it depends on memory content and exact cycle counts:
- the addresses actually read, and their wrap at 22 bits;
- the byte-wise marker rule in 8-bit format;
- the jump to the loop address and the continuation after it;
- the refusal to loop onto a second marker;
- the silence of software and reserved modes;
- the quiet abort on disable.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READY = 2'd1,
    ST_ISSUE = 2'd2,
    ST_CHECK = 2'd3
  } fetch_st_t;

  localparam logic [1:0] MODE_SOFT   = 2'b00;
  localparam logic [1:0] MODE_END    = 2'b01;
  localparam logic [1:0] MODE_REPEAT = 2'b10;
  localparam logic [1:0] MODE_RSVD   = 2'b11;

endpackage

// File: rtl/endmark_detect.sv
module endmark_detect #(
  parameter int DATA_W = 16
) (
  input  logic              wide,
  input  logic [DATA_W-1:0] word,
  output logic              is_mark
);
  localparam int LANES = DATA_W / 8;

  logic [LANES-1:0] lane_all_ones;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_all_ones[g] = &word[g*8 +: 8];
  end

  assign is_mark = wide ? (&word) : (|lane_all_ones);
endmodule

// File: rtl/addr_unit.sv
module addr_unit #(
  parameter int HI_W = 6,
  parameter int LO_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [HI_W+LO_W-1:0] load_val,
  input  logic                 incr,
  output logic [HI_W+LO_W-1:0] addr
);
  localparam int ADDR_W = HI_W + LO_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_val;
    end else if (incr) begin
      addr <= addr + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       fetch_req,
  input  logic [1:0] mode_in,
  input  logic       wide_in,
  input  logic       word_is_mark,
  output logic       start_now,
  output logic       issue_next,
  output logic       issue_loop,
  output logic       take_word,
  output logic       wide_q,
  output logic       chan_active,
  output logic       stop_pulse,
  output logic       stop_status
);
  fetch_st_t  state_q, state_d;
  logic       en_q;
  logic       from_loop_q;
  logic [1:0] mode_q;
  logic       stop_now;
  logic       auto_mode;

  assign auto_mode = (mode_in == MODE_END) || (mode_in == MODE_REPEAT);

  always_comb begin
    state_d    = state_q;
    start_now  = 1'b0;
    issue_next = 1'b0;
    issue_loop = 1'b0;
    take_word  = 1'b0;
    stop_now   = 1'b0;
    if (!enable) begin
      state_d = ST_IDLE;
    end else if (!en_q) begin
      start_now = 1'b1;
      state_d   = auto_mode ? ST_READY : ST_IDLE;
    end else begin
      case (state_q)
        ST_READY: begin
          if (fetch_req) begin
            issue_next = 1'b1;
            state_d    = ST_ISSUE;
          end
        end
        ST_ISSUE: state_d = ST_CHECK;
        ST_CHECK: begin
          if (!word_is_mark) begin
            take_word = 1'b1;
            state_d   = ST_READY;
          end else if (mode_q == MODE_REPEAT && !from_loop_q) begin
            issue_next = 1'b1;
            issue_loop = 1'b1;
            state_d    = ST_ISSUE;
          end else begin
            stop_now = 1'b1;
            state_d  = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      en_q        <= 1'b0;
      from_loop_q <= 1'b0;
      mode_q      <= MODE_SOFT;
      wide_q      <= 1'b0;
      chan_active <= 1'b0;
      stop_pulse  <= 1'b0;
      stop_status <= 1'b0;
    end else begin
      state_q     <= state_d;
      en_q        <= enable;
      chan_active <= (state_d != ST_IDLE);
      stop_pulse  <= stop_now;
      if (start_now) begin
        mode_q      <= mode_in;
        wide_q      <= wide_in;
        stop_status <= 1'b0;
        from_loop_q <= 1'b0;
      end else begin
        if (stop_now) stop_status <= 1'b1;
        if (issue_loop) from_loop_q <= 1'b1;
        else if (issue_next) from_loop_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq #(
  parameter int HI_W   = 6,
  parameter int LO_W   = 16,
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic [2*HI_W+2:0]    ctrl_word,
  input  logic [LO_W-1:0]      start_lo,
  input  logic [LO_W-1:0]      loop_lo,
  input  logic                 fetch_req,
  output logic                 mem_rd_en,
  output logic [HI_W+LO_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0]    mem_rd_data,
  output logic [DATA_W-1:0]    sample_data,
  output logic                 sample_valid,
  output logic                 chan_active,
  output logic                 stop_pulse,
  output logic                 stop_status
);
  localparam int ADDR_W    = HI_W + LO_W;
  localparam int START_LSB = 0;
  localparam int LOOP_LSB  = HI_W;
  localparam int MODE_LSB  = 2 * HI_W;
  localparam int WIDE_BIT  = MODE_LSB + 2;

  logic [ADDR_W-1:0] start_addr, loop_addr, cur_addr, load_val;
  logic start_now, issue_next, issue_loop, take_word, wide_q, word_is_mark;

  assign start_addr = {ctrl_word[START_LSB +: HI_W], start_lo};
  assign loop_addr  = {ctrl_word[LOOP_LSB +: HI_W], loop_lo};
  assign load_val   = start_now ? start_addr : loop_addr;

  fetch_ctrl ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .fetch_req   (fetch_req),
    .mode_in     (ctrl_word[MODE_LSB +: 2]),
    .wide_in     (ctrl_word[WIDE_BIT]),
    .word_is_mark(word_is_mark),
    .start_now   (start_now),
    .issue_next  (issue_next),
    .issue_loop  (issue_loop),
    .take_word   (take_word),
    .wide_q      (wide_q),
    .chan_active (chan_active),
    .stop_pulse  (stop_pulse),
    .stop_status (stop_status)
  );

  addr_unit #(.HI_W(HI_W), .LO_W(LO_W)) addr_i (
    .clk     (clk),
    .rst     (rst),
    .load    (start_now | issue_loop),
    .load_val(load_val),
    .incr    (take_word),
    .addr    (cur_addr)
  );

  endmark_detect #(.DATA_W(DATA_W)) mark_i (
    .wide   (wide_q),
    .word   (mem_rd_data),
    .is_mark(word_is_mark)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd_en    <= 1'b0;
      mem_rd_addr  <= '0;
      sample_data  <= '0;
      sample_valid <= 1'b0;
    end else begin
      mem_rd_en    <= issue_next;
      sample_valid <= take_word;
      if (issue_next) mem_rd_addr <= issue_loop ? loop_addr : cur_addr;
      if (take_word) sample_data <= mem_rd_data;
    end
  end
endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_rd_en,
  input logic              sample_valid,
  input logic [DATA_W-1:0] sample_data,
  input logic              chan_active,
  input logic              stop_pulse,
  input logic              stop_status
);
  p_single_read_r5: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  p_read_when_active_r3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> chan_active);

  p_valid_after_read_r4: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> $past(mem_rd_en, 2));

  p_no_marker_out_r6: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> (sample_data != {DATA_W{1'b1}}));

  p_stop_single_r7: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |=> !stop_pulse);

  p_stop_state_r7: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |-> (stop_status && !chan_active));

  p_start_clears_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(chan_active) |-> !stop_status);
endmodule

bind fetch_seq fetch_seq_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .mem_rd_en   (mem_rd_en),
  .sample_valid(sample_valid),
  .sample_data (sample_data),
  .chan_active (chan_active),
  .stop_pulse  (stop_pulse),
  .stop_status (stop_status)
);

// File: tb/fetch_seq_tb_top.sv
module fetch_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic        enable;
  logic [14:0] ctrl_word;
  logic [15:0] start_lo, loop_lo;
  logic        fetch_req;
  logic        mem_rd_en;
  logic [21:0] mem_rd_addr;
  logic [15:0] mem_rd_data;
  logic [15:0] sample_data;
  logic        sample_valid, chan_active, stop_pulse, stop_status;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [21:0] ov_addr [4];
  logic [15:0] ov_data [4];
  logic        ov_on   [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_seq dut_i (
    .clk(clk), .rst(rst), .enable(enable), .ctrl_word(ctrl_word),
    .start_lo(start_lo), .loop_lo(loop_lo), .fetch_req(fetch_req),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .sample_data(sample_data), .sample_valid(sample_valid),
    .chan_active(chan_active), .stop_pulse(stop_pulse), .stop_status(stop_status)
  );

  function automatic logic [15:0] word_at(input logic [21:0] a);
    for (int i = 0; i < 4; i++)
      if (ov_on[i] && ov_addr[i] == a) return ov_data[i];
    return {1'b0, a[14:8], 1'b0, a[6:0]};
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= word_at(mem_rd_addr);

  function automatic logic [14:0] mk_ctrl(input logic [1:0] mode, input logic wide,
                                          input logic [5:0] shi, input logic [5:0] lhi);
    return {wide, mode, lhi, shi};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_ov();
    for (int i = 0; i < 4; i++) ov_on[i] = 1'b0;
  endtask

  task automatic set_ov(input int i, input logic [21:0] a, input logic [15:0] d);
    ov_addr[i] = a; ov_data[i] = d; ov_on[i] = 1'b1;
  endtask

  // starts a channel; returns at a negedge with the enable edge taken
  task automatic start_chan(input logic [14:0] cw, input logic [15:0] slo, input logic [15:0] llo);
    enable = 1'b0;
    @(negedge clk);
    ctrl_word = cw; start_lo = slo; loop_lo = llo;
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic fetch_ok(input logic [21:0] a, input string tag);
    fetch_req = 1'b1;
    @(negedge clk); fetch_req = 1'b0;
    check(mem_rd_en && mem_rd_addr == a, {tag, " read address"}, {9'd0, mem_rd_en, mem_rd_addr}, {9'd0, 1'b1, a});
    @(negedge clk);
    @(negedge clk);
    check(sample_valid && sample_data == word_at(a), {tag, " sample"}, {15'd0, sample_valid, sample_data}, {15'd0, 1'b1, word_at(a)});
  endtask

  task automatic fetch_stop(input logic [21:0] a, input string tag);
    fetch_req = 1'b1;
    @(negedge clk); fetch_req = 1'b0;
    check(mem_rd_en && mem_rd_addr == a, {tag, " marker read"}, {10'd0, mem_rd_addr}, {10'd0, a});
    @(negedge clk);
    @(negedge clk);
    check(stop_pulse && !chan_active && stop_status && !sample_valid, {tag, " stop"},
          {stop_pulse, chan_active, stop_status, sample_valid}, 4'b1010);
    @(negedge clk);
    check(!stop_pulse && stop_status, {tag, " pulse width"}, {stop_pulse, stop_status}, 2'b01);
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int nreads;
    clear_ov();
    rst = 1'b1; enable = 1'b0; fetch_req = 1'b0;
    ctrl_word = '0; start_lo = '0; loop_lo = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!chan_active && !stop_status && !stop_pulse && !mem_rd_en && !sample_valid, "R1 reset",
          {chan_active, stop_status, stop_pulse, mem_rd_en, sample_valid}, 0);

    // R2, R4, R7: auto-end, 16-bit
    set_ov(0, 22'h020013, 16'hFFFF);
    start_chan(mk_ctrl(2'b01, 1'b1, 6'd2, 6'd0), 16'h0010, 16'h0);
    check(chan_active, "R2 start active", chan_active, 1);
    for (int k = 0; k < 3; k++) fetch_ok(22'h020010 + 22'(k), "R4 sequence");
    fetch_stop(22'h020013, "R7 auto-end");
    fetch_req = 1'b1;
    @(negedge clk); fetch_req = 1'b0;
    check(!mem_rd_en, "R7 no read after stop", mem_rd_en, 0);

    // R10: sticky until next start
    @(negedge clk);
    check(stop_status, "R10 sticky held", stop_status, 1);
    clear_ov();
    start_chan(mk_ctrl(2'b01, 1'b1, 6'd4, 6'd0), 16'h0000, 16'h0);
    check(!stop_status && chan_active, "R10 cleared by start", {stop_status, chan_active}, 2'b01);

    // R5: held request gives one read
    nreads = 0;
    fetch_req = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 2) fetch_req = 1'b0;
      if (mem_rd_en) nreads++;
    end
    check(nreads == 1, "R5 single outstanding", nreads, 1);

    // R6: 16-bit format passes byte 0xFF words
    set_ov(0, 22'h040001, 16'hFF34);
    set_ov(1, 22'h040002, 16'h12FF);
    fetch_ok(22'h040001, "R6 wide FF34 data");
    fetch_ok(22'h040002, "R6 wide 12FF data");
    // R6: 8-bit format stops on either byte
    start_chan(mk_ctrl(2'b01, 1'b0, 6'd4, 6'd0), 16'h0001, 16'h0);
    fetch_stop(22'h040001, "R6 narrow FF34 marker");
    start_chan(mk_ctrl(2'b01, 1'b0, 6'd4, 6'd0), 16'h0002, 16'h0);
    fetch_stop(22'h040002, "R6 narrow 12FF marker");
    start_chan(mk_ctrl(2'b01, 1'b0, 6'd4, 6'd0), 16'h0000, 16'h0);
    fetch_ok(22'h040000, "R6 narrow plain data");

    // R8: auto-repeat
    clear_ov();
    set_ov(0, 22'h010102, 16'hFFFF);
    start_chan(mk_ctrl(2'b10, 1'b1, 6'd1, 6'd3), 16'h0100, 16'h0200);
    fetch_ok(22'h010100, "R8 pre-loop");
    fetch_ok(22'h010101, "R8 pre-loop");
    fetch_req = 1'b1;
    @(negedge clk); fetch_req = 1'b0;
    check(mem_rd_en && mem_rd_addr == 22'h010102, "R8 marker read", {10'd0, mem_rd_addr}, {10'd0, 22'h010102});
    @(negedge clk);
    @(negedge clk);
    check(mem_rd_en && mem_rd_addr == 22'h030200 && !sample_valid && chan_active, "R8 loop read",
          {10'd0, mem_rd_addr}, {10'd0, 22'h030200});
    @(negedge clk);
    @(negedge clk);
    check(sample_valid && sample_data == word_at(22'h030200), "R8 loop word", sample_data, word_at(22'h030200));
    check(chan_active && !stop_status, "R8 stays active", {chan_active, stop_status}, 2'b10);
    fetch_ok(22'h030201, "R8 after loop");

    // R9: loop word is itself a marker
    set_ov(1, 22'h030200, 16'hFFFF);
    start_chan(mk_ctrl(2'b10, 1'b1, 6'd1, 6'd3), 16'h0102, 16'h0200);
    fetch_req = 1'b1;
    @(negedge clk); fetch_req = 1'b0;
    repeat (2) @(negedge clk);
    check(mem_rd_en && mem_rd_addr == 22'h030200, "R9 loop read", {10'd0, mem_rd_addr}, {10'd0, 22'h030200});
    repeat (2) @(negedge clk);
    check(stop_pulse && !chan_active && stop_status && !sample_valid, "R9 stop on loop marker",
          {stop_pulse, chan_active, stop_status, sample_valid}, 4'b1010);

    // R11: disable during a read
    clear_ov();
    start_chan(mk_ctrl(2'b01, 1'b1, 6'd7, 6'd0), 16'h0000, 16'h0);
    fetch_req = 1'b1;
    @(negedge clk); fetch_req = 1'b0;
    enable = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!sample_valid && !stop_pulse && !chan_active && !stop_status, "R11 quiet abort",
            {sample_valid, stop_pulse, chan_active, stop_status}, 0);
    end

    // R3: software and reserved modes never fetch
    for (int m = 0; m < 4; m += 3) begin
      start_chan(mk_ctrl(2'(m), 1'b1, 6'd0, 6'd0), 16'h0000, 16'h0);
      nreads = 0;
      fetch_req = 1'b1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (mem_rd_en || chan_active) nreads++;
      end
      fetch_req = 1'b0;
      check(nreads == 0, "R3 no fetch in mode", nreads, 0);
    end

    // R12: address wrap
    start_chan(mk_ctrl(2'b01, 1'b1, 6'h3F, 6'd0), 16'hFFFF, 16'h0);
    fetch_ok(22'h3FFFFF, "R12 top word");
    fetch_ok(22'h000000, "R12 wrapped word");

    // R4, R7 sweep over play lengths
    for (int n = 1; n <= 6; n++) begin
      clear_ov();
      set_ov(0, {6'd5, 16'(n * 16 + n)}, 16'hFFFF);
      start_chan(mk_ctrl(2'b01, 1'b1, 6'd5, 6'd0), 16'(n * 16), 16'h0);
      for (int k = 0; k < n; k++) fetch_ok({6'd5, 16'(n * 16 + k)}, "R4 sweep");
      fetch_stop({6'd5, 16'(n * 16 + n)}, "R7 sweep");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule